// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block is a blocking data cache that serves byte reads and writes from a processor and keeps whole lines in a small set-associative store. Each byte address is cut into a tag, a set index and a byte offset. The tag is compared against every way of the selected set at once. A hit completes without any memory traffic. A miss picks a victim way and writes that victim back as a full line only when it holds modified data. It then fetches the requested line as a burst of ascending words and repeats the lookup, which now hits.

Victim selection always prefers an empty way. When the set is full, a free-running pseudo-random source picks the way, and the most recently used way of the set is never chosen. Processor writes allocate on a miss: the line is fetched first, the byte is merged into it, and the line is marked modified. Only one request is in flight at a time, and the processor port stays closed until the response pulse.

Top module: `sa_wb_cache`

## Requirements
- R1: A byte address is split into byte offset (low log2(LINE_BYTES) bits), set index (next log2(SETS) bits) and tag (remaining upper bits). A read returns the byte at the offset within the cached line, and that byte equals the last value written to that address, or the initial memory content if the address was never written.
- R2: The lookup compares the tag against all ways of the set in parallel, and at most one valid way of a set ever matches.
- R3: On a hit, resp_valid is high for one cycle at the second rising edge after the edge that accepted the request, and no memory command is issued.
- R4: After reset all lines are invalid, req_ready is 1, and resp_valid, mem_cmd_valid and mem_wvalid are 0. The first access to any line issues one read command.
- R5: An empty way of the set is filled before any valid way is replaced, so WAYS distinct lines of one set read after reset all stay resident.
- R6: When every way of a set is valid, the replaced way is never the most recently used way of that set. Every hit and every fill makes its way the most recently used.
- R7: A line is marked modified by a processor write. On replacement it is written back only if modified, and a clean line is never written back.
- R8: A write-back sends mem_cmd_write=1 with the line-aligned base address, then LINE_BYTES/WORD_BYTES words on mem_wdata in ascending address order. Byte k of beat b is line byte b*WORD_BYTES+k. mem_wvalid and mem_wdata hold until mem_wready.
- R9: A write-back burst completes before the refill command is issued. The refill is a read command (mem_cmd_write=0) for the requested line, followed by the same number of beats in the same word order, one accepted per cycle in which mem_rvalid is high.
- R10: The cache is blocking. req_ready stays 0 from the accepting edge until the response pulse, so requests are handled one at a time.
- R11: A write miss fetches the line, merges the byte and marks the line modified, without writing memory directly. A write response returns the written byte on resp_rdata.
- R12: mem_cmd_valid, mem_cmd_addr and mem_cmd_write stay stable until mem_cmd_ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Cache can accept a request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Read byte, or the written byte for writes |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_cmd_addr | output | ADDR_W | Line-aligned byte address |
| mem_wvalid | output | 1 | Write-back beat present |
| mem_wready | input | 1 | Memory accepts the beat |
| mem_wdata | output | WORD_BYTES*8 | Write-back beat data |
| mem_rvalid | input | 1 | Refill beat present |
| mem_rdata | input | WORD_BYTES*8 | Refill beat data |

## Verification
The in-line properties check the following on every cycle:
- no two valid ways of a set match the same tag;
- the chosen victim is never the protected way of a full set, and it is always empty when an empty way exists;
- a write-back burst only runs for a modified line and finishes before the refill;
- the lookup right after a refill always hits;
- memory command and write beats stay stable while stalled.

Some behaviours only the bench scenarios can show:
- that data survives eviction and refill correctly;
- that a clean line never reaches memory while a modified one eventually does;
- that the recently used line outlives a series of conflicting misses;
- the exact hit latency.

The bench shows these against a byte-level reference memory, under random ready and valid gaps on the memory side.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB_CMD,
        ST_WB_DATA,
        ST_RF_CMD,
        ST_RF_DATA
    } ctl_state_e;

    localparam logic [7:0] LFSR_SEED = 8'hA5;

    // 8-bit maximal-length shift register step
    function automatic logic [7:0] lfsr8_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 7,
    parameter int WAY_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [WAYS-1:0]             set_valid,
    input  logic [TAG_W-1:0]            look_tag,
    input  logic                        look_en,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);

    logic [WAYS-1:0] match;

    // one equality comparator per way, all in parallel
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid[w] && (set_tags[w] == look_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    // R2: never two valid ways holding the same tag
    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        look_en |-> $onehot0(match));

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick
    import cache_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAYS-1:0]   set_valid,
    input  logic [WAY_W-1:0]  mru_way,
    output logic [WAY_W-1:0]  victim
);

    logic [7:0]       lfsr_q;
    logic [WAY_W-1:0] rand_way;
    logic [WAY_W-1:0] guarded_way;
    logic [WAY_W-1:0] empty_way;
    logic             has_empty;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= LFSR_SEED;
        else     lfsr_q <= lfsr8_next(lfsr_q);
    end

    assign rand_way    = lfsr_q[WAY_W-1:0];
    // step past the protected way; WAYS is a power of two so this wraps
    assign guarded_way = (rand_way == mru_way) ? rand_way + WAY_W'(1) : rand_way;

    always_comb begin
        empty_way = '0;
        has_empty = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                empty_way = WAY_W'(w);
                has_empty = 1'b1;
            end
        end
    end

    assign victim = has_empty ? empty_way : guarded_way;

    // R6: a full set never loses its most recently used way
    assert_victim_not_mru_R6: assert property (@(posedge clk) disable iff (rst)
        (&set_valid) |-> (victim != mru_way));

    // R5: empty ways are taken before valid ones
    assert_empty_first_R5: assert property (@(posedge clk) disable iff (rst)
        !(&set_valid) |-> !set_valid[victim]);

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 8,
    parameter int WORD_BYTES = 4,
    parameter int IDX_W      = 2,
    parameter int WAY_W      = 2,
    parameter int OFF_W      = 3,
    parameter int BEAT_W     = 1
) (
    input  logic                                clk,
    input  logic [IDX_W-1:0]                    set_sel,
    output logic [WAYS-1:0][LINE_BYTES*8-1:0]   rd_lines,
    input  logic                                byte_we,
    input  logic [WAY_W-1:0]                    byte_way,
    input  logic [OFF_W-1:0]                    byte_off,
    input  logic [7:0]                          byte_data,
    input  logic                                word_we,
    input  logic [WAY_W-1:0]                    word_way,
    input  logic [BEAT_W-1:0]                   word_idx,
    input  logic [WORD_BYTES*8-1:0]             word_data
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;

    logic [LINE_W-1:0] line_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (byte_we)
            line_q[set_sel][byte_way][{byte_off, 3'b000} +: 8] <= byte_data;
        if (word_we)
            line_q[set_sel][word_way][int'(word_idx) * WORD_W +: WORD_W] <= word_data;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_lines[w] = line_q[set_sel][w];
    end

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [7:0]                req_wdata,
    output logic                      req_ready,
    output logic                      resp_valid,
    output logic [7:0]                resp_rdata,
    output logic                      mem_cmd_valid,
    input  logic                      mem_cmd_ready,
    output logic                      mem_cmd_write,
    output logic [ADDR_W-1:0]         mem_cmd_addr,
    output logic                      mem_wvalid,
    input  logic                      mem_wready,
    output logic [WORD_BYTES*8-1:0]   mem_wdata,
    input  logic                      mem_rvalid,
    input  logic [WORD_BYTES*8-1:0]   mem_rdata
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int BEATS  = LINE_BYTES / WORD_BYTES;
    localparam int BEAT_W = width_of(BEATS);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
    } req_t;

    ctl_state_e        state_q;
    req_t              req_q;
    logic [WAY_W-1:0]  victim_q;
    logic [BEAT_W-1:0] beat_q;

    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [WAY_W-1:0]  mru_q   [SETS];

    logic [OFF_W-1:0]             cur_off;
    logic [IDX_W-1:0]             cur_idx;
    logic [TAG_W-1:0]             cur_tag;
    logic [WAYS-1:0][TAG_W-1:0]   set_tags;
    logic [WAYS-1:0]              set_valid;
    logic [WAYS-1:0]              set_dirty;
    logic                         lk_hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic [WAYS-1:0][LINE_W-1:0]  rd_lines;
    logic [LINE_W-1:0]            hit_line;
    logic [LINE_W-1:0]            vict_line;
    logic [7:0]                   hit_byte;
    logic                         last_beat;
    logic                         in_lookup;

    assign cur_off   = req_q.addr[OFF_W-1:0];
    assign cur_idx   = req_q.addr[OFF_W +: IDX_W];
    assign cur_tag   = req_q.addr[ADDR_W-1 -: TAG_W];
    assign set_valid = valid_q[cur_idx];
    assign set_dirty = dirty_q[cur_idx];
    assign in_lookup = (state_q == ST_LOOKUP);

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[cur_idx][w];
    end

    cache_tag_match #(
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .WAY_W(WAY_W)
    ) u_match (
        .clk      (clk),
        .rst      (rst),
        .set_tags (set_tags),
        .set_valid(set_valid),
        .look_tag (cur_tag),
        .look_en  (in_lookup),
        .hit      (lk_hit),
        .hit_way  (hit_way)
    );

    cache_victim_pick #(
        .WAYS (WAYS),
        .WAY_W(WAY_W)
    ) u_pick (
        .clk      (clk),
        .rst      (rst),
        .set_valid(set_valid),
        .mru_way  (mru_q[cur_idx]),
        .victim   (victim)
    );

    cache_line_store #(
        .SETS      (SETS),
        .WAYS      (WAYS),
        .LINE_BYTES(LINE_BYTES),
        .WORD_BYTES(WORD_BYTES),
        .IDX_W     (IDX_W),
        .WAY_W     (WAY_W),
        .OFF_W     (OFF_W),
        .BEAT_W    (BEAT_W)
    ) u_store (
        .clk      (clk),
        .set_sel  (cur_idx),
        .rd_lines (rd_lines),
        .byte_we  (in_lookup && lk_hit && req_q.wr),
        .byte_way (hit_way),
        .byte_off (cur_off),
        .byte_data(req_q.wdata),
        .word_we  ((state_q == ST_RF_DATA) && mem_rvalid),
        .word_way (victim_q),
        .word_idx (beat_q),
        .word_data(mem_rdata)
    );

    assign hit_line  = rd_lines[hit_way];
    assign vict_line = rd_lines[victim_q];
    assign hit_byte  = hit_line[{cur_off, 3'b000} +: 8];
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

    // memory side outputs follow the state register
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_cmd_valid = (state_q == ST_WB_CMD) || (state_q == ST_RF_CMD);
    assign mem_cmd_write = (state_q == ST_WB_CMD);
    assign mem_cmd_addr  = (state_q == ST_WB_CMD)
                         ? {tag_q[cur_idx][victim_q], cur_idx, {OFF_W{1'b0}}}
                         : {cur_tag, cur_idx, {OFF_W{1'b0}}};
    assign mem_wvalid    = (state_q == ST_WB_DATA);
    assign mem_wdata     = vict_line[int'(beat_q) * WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            victim_q   <= '0;
            beat_q     <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                mru_q[s]   <= '0;
            end
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q   <= '{wr: req_write, addr: req_addr, wdata: req_wdata};
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (lk_hit) begin
                        mru_q[cur_idx] <= hit_way;
                        if (req_q.wr) dirty_q[cur_idx][hit_way] <= 1'b1;
                        resp_valid <= 1'b1;
                        resp_rdata <= req_q.wr ? req_q.wdata : hit_byte;
                        state_q    <= ST_IDLE;
                    end else begin
                        victim_q <= victim;
                        beat_q   <= '0;
                        state_q  <= (set_valid[victim] && set_dirty[victim]) ? ST_WB_CMD : ST_RF_CMD;
                    end
                end
                ST_WB_CMD: begin
                    if (mem_cmd_ready) state_q <= ST_WB_DATA;
                end
                ST_WB_DATA: begin
                    if (mem_wready) begin
                        beat_q <= beat_q + BEAT_W'(1);
                        if (last_beat) begin
                            beat_q  <= '0;
                            state_q <= ST_RF_CMD;
                        end
                    end
                end
                ST_RF_CMD: begin
                    if (mem_cmd_ready) state_q <= ST_RF_DATA;
                end
                ST_RF_DATA: begin
                    if (mem_rvalid) begin
                        beat_q <= beat_q + BEAT_W'(1);
                        if (last_beat) begin
                            beat_q                      <= '0;
                            tag_q[cur_idx][victim_q]    <= cur_tag;
                            valid_q[cur_idx][victim_q]  <= 1'b1;
                            dirty_q[cur_idx][victim_q]  <= 1'b0;
                            mru_q[cur_idx]              <= victim_q;
                            state_q                     <= ST_LOOKUP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: a response only follows a lookup cycle
    assert_resp_after_lookup_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(state_q) == ST_LOOKUP));

    // R7: a write-back burst only drains a valid, modified line
    assert_wb_only_dirty_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WB_DATA) |-> (dirty_q[cur_idx][victim_q] && valid_q[cur_idx][victim_q]));

    // R8: a stalled write-back beat holds its data
    assert_wbeat_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata)));

    // R9: refill command after a write-back only once its last beat went out
    assert_wb_before_refill_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RF_CMD && $past(state_q) == ST_WB_DATA) |-> $past(mem_wready && last_beat));

    // R11: the lookup after a refill always hits
    assert_refill_hits_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && $past(state_q) == ST_RF_DATA) |-> lk_hit);

    // R12: command fields hold while stalled
    assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));

endmodule

// File: tb/test_sa_wb_cache.sv
module test_sa_wb_cache;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int WAYS       = 4;
    localparam int SETS       = 4;
    localparam int LINE_BYTES = 8;
    localparam int WORD_BYTES = 4;
    localparam int OFF_W      = 3;
    localparam int IDX_W      = 2;
    localparam int BEATS      = LINE_BYTES / WORD_BYTES;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int NLINES     = MEM_BYTES / LINE_BYTES;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write, req_ready, resp_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0] req_wdata, resp_rdata;
    logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
    logic [ADDR_W-1:0] mem_cmd_addr;
    logic mem_wvalid, mem_wready, mem_rvalid;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] mem_b [MEM_BYTES];
    logic [7:0] ref_b [MEM_BYTES];
    bit         dirty_exp [NLINES];
    int         wb_line_cnt [NLINES];
    int         cmd_rd_cnt = 0;
    int         cmd_wr_cnt = 0;
    int         cur_line = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sa_wb_cache #(
        .ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS),
        .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
    ) i_sa_wb_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seed_byte(input int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx, input int off);
        return ADDR_W'((tag << (IDX_W + OFF_W)) | (idx << OFF_W) | off);
    endfunction

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic report_and_finish();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // memory model: random stalls on every channel
    bit hold_pend = 0;
    logic [ADDR_W-1:0] hold_addr;
    initial begin
        mem_cmd_ready = 1'b0;
        mem_wready    = 1'b0;
        mem_rvalid    = 1'b0;
        mem_rdata     = '0;
        forever begin
            @(negedge clk);
            if (hold_pend) begin
                check(mem_cmd_valid && mem_cmd_addr == hold_addr, "R12",
                      mem_cmd_addr, hold_addr);
                hold_pend = 0;
            end
            if (rst) begin
                mem_cmd_ready = 1'b0;
                continue;
            end
            mem_cmd_ready = ($urandom % 4) != 0;
            if (mem_cmd_valid && !mem_cmd_ready) begin
                hold_pend = 1;
                hold_addr = mem_cmd_addr;
            end else if (mem_cmd_valid) begin
                int base;
                int line;
                base = int'(mem_cmd_addr);
                line = base >> OFF_W;
                check(base % LINE_BYTES == 0, "R8", base, base - base % LINE_BYTES);
                if (mem_cmd_write) begin
                    int n;
                    bit same;
                    cmd_wr_cnt++;
                    wb_line_cnt[line]++;
                    check(dirty_exp[line], "R7", 1, 0);
                    check(line != cur_line, "R9", line, cur_line);
                    @(negedge clk);
                    mem_cmd_ready = 1'b0;
                    n = 0;
                    while (n < BEATS) begin
                        mem_wready = $urandom % 2;
                        if (mem_wvalid && mem_wready) begin
                            for (int k = 0; k < WORD_BYTES; k++)
                                mem_b[base + n * WORD_BYTES + k] = mem_wdata[k*8 +: 8];
                            n++;
                        end
                        @(negedge clk);
                    end
                    mem_wready = 1'b0;
                    same = 1;
                    for (int k = 0; k < LINE_BYTES; k++)
                        if (mem_b[base + k] !== ref_b[base + k]) same = 0;
                    check(same, "R8", 0, 1);
                    dirty_exp[line] = 0;
                end else begin
                    int n;
                    cmd_rd_cnt++;
                    check(line == cur_line, "R9", line, cur_line);
                    @(negedge clk);
                    mem_cmd_ready = 1'b0;
                    n = 0;
                    while (n < BEATS) begin
                        mem_rvalid = $urandom % 2;
                        for (int k = 0; k < WORD_BYTES; k++)
                            mem_rdata[k*8 +: 8] = mem_b[base + n * WORD_BYTES + k];
                        if (mem_rvalid) n++;
                        @(negedge clk);
                    end
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                          output logic [7:0] q, output int lat, output int rds, output int wrs);
        int r0;
        int w0;
        bit blk_ok;
        r0 = cmd_rd_cnt;
        w0 = cmd_wr_cnt;
        blk_ok = 1;
        cur_line = int'(a) >> OFF_W;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin
            if (req_ready) blk_ok = 0;
            @(negedge clk);
            lat++;
        end
        q   = resp_rdata;
        rds = cmd_rd_cnt - r0;
        wrs = cmd_wr_cnt - w0;
        check(blk_ok, "R10", 1, 0);
        if (wr) begin
            check(q == d, "R11", q, d);
            ref_b[a] = d;
            dirty_exp[int'(a) >> OFF_W] = 1;
        end else begin
            check(q == ref_b[a], "R1", q, ref_b[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        report_and_finish();
    end

    initial begin
        logic [7:0] q;
        int lat, rds, wrs;
        void'($urandom(32'd2024));
        for (int a = 0; a < MEM_BYTES; a++) begin
            mem_b[a] = seed_byte(a);
            ref_b[a] = seed_byte(a);
        end
        for (int l = 0; l < NLINES; l++) begin
            dirty_exp[l]   = 0;
            wb_line_cnt[l] = 0;
        end
        rst = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: idle outputs after reset
        check(req_ready == 1'b1, "R4", req_ready, 1);
        check(resp_valid == 1'b0, "R4", resp_valid, 0);
        check(mem_cmd_valid == 1'b0, "R4", mem_cmd_valid, 0);
        check(mem_wvalid == 1'b0, "R4", mem_wvalid, 0);

        // R5: fill every way of set 2 from empty, all must remain
        for (int t = 1; t <= WAYS; t++) begin
            access(0, mk_addr(t, 2, t), 8'h00, q, lat, rds, wrs);
            check(rds == 1 && wrs == 0, "R4", rds, 1);
        end
        for (int t = 1; t <= WAYS; t++) begin
            access(0, mk_addr(t, 2, 7 - t), 8'h00, q, lat, rds, wrs);
            check(rds == 0 && wrs == 0, "R5", rds, 0);
            check(lat == 2, "R3", lat, 2);
        end

        // R6: the most recently used line survives conflicting misses
        for (int t = 1; t <= WAYS; t++) access(0, mk_addr(t, 1, 0), 8'h00, q, lat, rds, wrs);
        access(0, mk_addr(1, 1, 3), 8'h00, q, lat, rds, wrs);
        for (int k = 0; k < 8; k++) begin
            access(0, mk_addr(10 + k, 1, k), 8'h00, q, lat, rds, wrs);
            check(rds == 1, "R6", rds, 1);
            access(0, mk_addr(1, 1, k), 8'h00, q, lat, rds, wrs);
            check(rds == 0, "R6", rds, 0);
        end

        // R11 and R7: write miss allocates, dirty line written back once
        begin
            int wb_total;
            int line1;
            line1 = int'(mk_addr(1, 3, 0)) >> OFF_W;
            access(1, mk_addr(1, 3, 5), 8'hC3, q, lat, rds, wrs);
            check(rds == 1 && wrs == 0, "R11", rds, 1);
            access(0, mk_addr(1, 3, 5), 8'h00, q, lat, rds, wrs);
            check(rds == 0 && q == 8'hC3, "R11", q, 8'hC3);
            for (int t = 2; t <= WAYS; t++) access(0, mk_addr(t, 3, 1), 8'h00, q, lat, rds, wrs);
            wb_total = 0;
            for (int i = 0; i < 60 && wb_line_cnt[line1] == 0; i++) begin
                access(0, mk_addr(20 + (i % 12), 3, i % LINE_BYTES), 8'h00, q, lat, rds, wrs);
                wb_total += wrs;
            end
            check(wb_line_cnt[line1] == 1, "R7", wb_line_cnt[line1], 1);
            check(wb_total == 1, "R7", wb_total, 1);
            access(0, mk_addr(1, 3, 5), 8'h00, q, lat, rds, wrs);
            check(rds == 1 && q == 8'hC3, "R8", q, 8'hC3);
        end

        // constrained random mix over a few conflicting tags
        for (int i = 0; i < 1500; i++) begin
            bit wr;
            logic [ADDR_W-1:0] a;
            wr = ($urandom % 10) < 4;
            a  = mk_addr($urandom % 8, $urandom % SETS, $urandom % LINE_BYTES);
            access(wr, a, 8'($urandom), q, lat, rds, wrs);
            if (rds == 0) check(lat == 2 && wrs == 0, "R3", lat, 2);
        end

        repeat (5) @(negedge clk);
        report_and_finish();
    end

endmodule